// File: doc/BRIEF.md
# I2C Slave Address Front End with General-Call Commands

This block sits on a pair of oversampled I2C lines and acts as the address-phase front end of a 7-bit slave. It resynchronises SCL and SDA to the system clock and finds START and STOP conditions. It shifts in the first byte after each START. It acknowledges that byte when it carries the block's own address or, unless general calls are disabled, the all-zero general-call address. The acknowledge is driven through an open-drain enable: a high `sda_oe_o` pulls SDA low.

After an accepted general call, the block reads the command byte. Two even command values let a bus master rewrite the low, programmable bits of the own address. One of them first clears the block's status, and the other leaves status untouched. Command bytes with a set least significant bit, which form the hardware flavour of the general call, are left alone, and so are all other even values. The new address bits come from the byte that follows the command. Only the address phase is acknowledged for a plain own-address match. Data beyond that phase is neither stored nor acknowledged, and the block never stretches SCL.

Status is kept in two sticky flags: an address match and a general call. A clear pulse resets both flags. A registered interrupt follows the general-call flag while the interrupt enable is high. Control and status are plain level pins; the block has no streaming data path, so no valid/ready interface and no back-pressure rules apply.

Top module: `i2c_gc_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP or a repeated START in any phase abandons the transaction, releases SDA, and makes the block wait for the next START.
- R2: A first byte whose upper seven bits equal `own_addr_o` is acknowledged, whatever its R/W bit. The block holds `sda_oe_o` high for exactly the ninth SCL pulse, changes it only while SCL is low, and sets `match_o`.
- R3: A first byte of 0x00 with `gc_dis_i` low is acknowledged and sets both `gc_flag_o` and `match_o`.
- R4: `irq_o` goes high one clock after `gc_flag_o` is high while `irq_en_i` is high. It stays low whenever `irq_en_i` is low.
- R5: With `gc_dis_i` high, a first byte of 0x00 gets no acknowledge and changes no flag.
- R6: Any other first byte gets no acknowledge and sets no flag.
- R7: After an accepted general call, a command byte with bit 0 set gets no acknowledge, and the own address and flags stay as they were.
- R8: Command 0x04 is acknowledged, and so is the byte after it. Bits [3:1] of that following byte replace `own_addr_o[2:0]`, and the flags stay set.
- R9: Command 0x06 clears `gc_flag_o` and `match_o`. Its following byte is acknowledged and loads `own_addr_o[2:0]` from bits [3:1]. `own_addr_o[6:3]` changes only through `addr_wr_i`.
- R10: Any even command other than 0x04 and 0x06, 0x00 included, gets no acknowledge and leaves the own address and flags unchanged.
- R11: After reset, `sda_oe_o`, `match_o`, `gc_flag_o` and `irq_o` are low and `own_addr_o` equals `RST_ADDR`. A pulse on `addr_wr_i` loads all seven bits, and a pulse on `stat_clr_i` clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (resolved bus level) |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| gc_dis_i | input | 1 | High makes the block ignore general calls |
| irq_en_i | input | 1 | Interrupt enable |
| addr_wr_i | input | 1 | Load pulse for the whole own address |
| addr_wr_val_i | input | ADDR_W | Value loaded by `addr_wr_i` |
| stat_clr_i | input | 1 | Clears both status flags |
| own_addr_o | output | ADDR_W | Current own address |
| match_o | output | 1 | Sticky: slave address matched |
| gc_flag_o | output | 1 | Sticky: general call received |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 7-bit address with three programmable bits, two synchroniser stages and a reset address of 0x2A. At this size all 256 first-byte values can be swept against the address comparator. All 256 command bytes can also be swept after a general call, with the new address bits and flag states computed arithmetically from each command and data byte. The same configuration reaches the disable and interrupt-enable combinations, aborts by STOP and by repeated START in the middle of a byte, and a full reload of the own address.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } gc_state_e;

  typedef enum logic [1:0] {
    CK_NONE,
    CK_LOAD,
    CK_RSTLOAD
  } cmd_kind_e;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] CMD_LOAD     = 8'h04;
  localparam logic [7:0] CMD_RSTLOAD  = 8'h06;

endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // Line events: SCL edges, and SDA edges seen while SCL stays high.
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_gc_shift.sv
module i2c_gc_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       shift_i,
  input  logic       bit_i,
  output logic [7:0] byte_o,
  output logic       done_o
);

  logic [6:0] sh_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[5:0], bit_i};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  // The byte is complete on the eighth rising SCL; present it in that cycle.
  assign byte_o = {sh_q, bit_i};
  assign done_o = shift_i & (cnt_q == 3'd7);

endmodule

// File: rtl/i2c_gc_decode.sv
module i2c_gc_decode
  import i2c_gc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_dis_i,
  output logic              addr_hit_o,
  output logic              gc_hit_o,
  output cmd_kind_e         cmd_kind_o
);

  assign addr_hit_o = (byte_i[7 -: ADDR_W] == own_addr_i);
  assign gc_hit_o   = (byte_i == GC_ADDR_BYTE) & ~gc_dis_i;

  always_comb begin
    cmd_kind_o = CK_NONE;
    if (!byte_i[0]) begin
      if (byte_i == CMD_RSTLOAD)   cmd_kind_o = CK_RSTLOAD;
      else if (byte_i == CMD_LOAD) cmd_kind_o = CK_LOAD;
    end
  end

endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2c_gc_pkg::*;
#(
  parameter int              ADDR_W      = 7,
  parameter int              PROG_W      = 3,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              gc_dis_i,
  input  logic              irq_en_i,
  input  logic              addr_wr_i,
  input  logic [ADDR_W-1:0] addr_wr_val_i,
  input  logic              stat_clr_i,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic              match_o,
  output logic              gc_flag_o,
  output logic              irq_o
);

  localparam int FIX_W = ADDR_W - PROG_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] byte_w;
  logic       byte_done;
  logic       addr_hit, gc_hit;
  cmd_kind_e  cmd_k;

  gc_state_e         state_q, nxt_q;
  logic              ack_half_q;
  logic              oe_q;
  logic [ADDR_W-1:0] own_q;
  logic              match_q, gc_q, irq_q;

  logic in_byte, shift_en, shift_clr;

  i2c_gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  assign in_byte   = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DATA);
  assign shift_en  = scl_rise & in_byte;
  assign shift_clr = start_ev | ((state_q == ST_ACK) & scl_fall & ack_half_q);

  i2c_gc_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (shift_clr),
    .shift_i (shift_en),
    .bit_i   (sda_s),
    .byte_o  (byte_w),
    .done_o  (byte_done)
  );

  i2c_gc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .byte_i     (byte_w),
    .own_addr_i (own_q),
    .gc_dis_i   (gc_dis_i),
    .addr_hit_o (addr_hit),
    .gc_hit_o   (gc_hit),
    .cmd_kind_o (cmd_k)
  );

  // Transaction sequencer, flags and own-address register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      ack_half_q <= 1'b0;
      oe_q       <= 1'b0;
      own_q      <= RST_ADDR;
      match_q    <= 1'b0;
      gc_q       <= 1'b0;
    end else begin
      if (stat_clr_i) begin
        match_q <= 1'b0;
        gc_q    <= 1'b0;
      end
      if (addr_wr_i) own_q <= addr_wr_val_i;

      if (start_ev) begin
        state_q    <= ST_ADDR;
        oe_q       <= 1'b0;
        ack_half_q <= 1'b0;
      end else if (stop_ev) begin
        state_q    <= ST_IDLE;
        oe_q       <= 1'b0;
        ack_half_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: if (byte_done) begin
            if (gc_hit) begin
              match_q <= 1'b1;
              gc_q    <= 1'b1;
              nxt_q   <= ST_CMD;
              state_q <= ST_ACK;
            end else if (addr_hit) begin
              match_q <= 1'b1;
              nxt_q   <= ST_SKIP;
              state_q <= ST_ACK;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_CMD: if (byte_done) begin
            case (cmd_k)
              CK_RSTLOAD: begin
                match_q <= 1'b0;
                gc_q    <= 1'b0;
                nxt_q   <= ST_DATA;
                state_q <= ST_ACK;
              end
              CK_LOAD: begin
                nxt_q   <= ST_DATA;
                state_q <= ST_ACK;
              end
              default: state_q <= ST_SKIP;
            endcase
          end
          ST_DATA: if (byte_done) begin
            own_q[PROG_W-1:0] <= byte_w[PROG_W:1];
            nxt_q   <= ST_SKIP;
            state_q <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_half_q) begin
              oe_q       <= 1'b1;
              ack_half_q <= 1'b1;
            end else begin
              oe_q       <= 1'b0;
              ack_half_q <= 1'b0;
              state_q    <= nxt_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_en_i & gc_q;
  end

  assign sda_oe_o   = oe_q;
  assign own_addr_o = own_q;
  assign match_o    = match_q;
  assign gc_flag_o  = gc_q;
  assign irq_o      = irq_q;

  // Width of the fixed address part, kept for readers of the parameter set.
  if (FIX_W < 1) begin : g_bad_split
    initial $display("i2c_gc_slave: PROG_W must be smaller than ADDR_W");
  end

endmodule

// File: rtl/i2c_gc_checker.sv
module i2c_gc_checker #(
  parameter int ADDR_W = 7,
  parameter int PROG_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_ev,
  input logic              sda_oe_o,
  input logic              gc_dis_i,
  input logic              irq_en_i,
  input logic              addr_wr_i,
  input logic [ADDR_W-1:0] own_addr_o,
  input logic              match_o,
  input logic              gc_flag_o,
  input logic              irq_o
);

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe_o); // R1

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_s)); // R2

  AST_GC_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    gc_flag_o |-> match_o); // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(irq_en_i) && $past(gc_flag_o))); // R4

  AST_GC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_flag_o) |-> !$past(gc_dis_i)); // R5

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_wr_i) |-> $stable(own_addr_o[ADDR_W-1:PROG_W])); // R9

endmodule

bind i2c_gc_slave i2c_gc_checker #(.ADDR_W(ADDR_W), .PROG_W(PROG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .stop_ev    (stop_ev),
  .sda_oe_o   (sda_oe_o),
  .gc_dis_i   (gc_dis_i),
  .irq_en_i   (irq_en_i),
  .addr_wr_i  (addr_wr_i),
  .own_addr_o (own_addr_o),
  .match_o    (match_o),
  .gc_flag_o  (gc_flag_o),
  .irq_o      (irq_o)
);

// File: tb/tb_i2c_gc_slave.sv
module tb_i2c_gc_slave;

  localparam int Q = 3;
  localparam logic [6:0] RST_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic gc_dis = 1'b0;
  logic irq_en = 1'b0;
  logic addr_wr = 1'b0;
  logic [6:0] addr_wr_val = '0;
  logic stat_clr = 1'b0;
  logic [6:0] own_addr;
  logic match, gc_flag, irq;

  int errors = 0;
  int checks = 0;
  int oe_glitch = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_gc_slave dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_bus),
    .sda_oe_o      (sda_oe),
    .gc_dis_i      (gc_dis),
    .irq_en_i      (irq_en),
    .addr_wr_i     (addr_wr),
    .addr_wr_val_i (addr_wr_val),
    .stat_clr_i    (stat_clr),
    .own_addr_o    (own_addr),
    .match_o       (match),
    .gc_flag_o     (gc_flag),
    .irq_o         (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(1);
    scl_m = 1'b1; wq(1);
    if (sda_oe) oe_glitch++;
    wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    acked = (sda_bus == 1'b0);
    wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1; @(negedge clk);
    stat_clr = 1'b0; @(negedge clk);
  endtask

  task automatic load_addr(input logic [6:0] a);
    addr_wr_val = a; addr_wr = 1'b1; @(negedge clk);
    addr_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d;
    logic [6:0] exp_addr;
    bit exp_ack;

    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11 oe at reset", int'(sda_oe), 0);
    check("R11 match at reset", int'(match), 0);
    check("R11 gc at reset", int'(gc_flag), 0);
    check("R11 irq at reset", int'(irq), 0);
    check("R11 addr at reset", int'(own_addr), int'(RST_ADDR));
    rst_n = 1'b1;
    wq(2);

    // R2 R6: sweep every first byte with general calls enabled
    irq_en = 1'b1;
    for (int b = 0; b < 256; b++) begin
      pulse_clr();
      do_start();
      send_byte(8'(b), ack);
      do_stop();
      exp_ack = (b[7:1] == RST_ADDR) || (b == 0);
      check($sformatf("R2 R3 R6 ack byte %02h", b), int'(ack), int'(exp_ack));
      check($sformatf("R2 R6 match byte %02h", b), int'(match), int'(exp_ack));
      check($sformatf("R3 R6 gc byte %02h", b), int'(gc_flag), int'(b == 0));
      check($sformatf("R4 irq byte %02h", b), int'(irq), int'(b == 0));
    end

    // R4 R5: general call under each disable / enable combination
    for (int k = 0; k < 4; k++) begin
      gc_dis = k[1];
      irq_en = k[0];
      pulse_clr();
      do_start();
      send_byte(8'h00, ack);
      do_stop();
      check($sformatf("R5 ack dis=%0d", k[1]), int'(ack), int'(!k[1]));
      check($sformatf("R5 gc dis=%0d", k[1]), int'(gc_flag), int'(!k[1]));
      check($sformatf("R5 match dis=%0d", k[1]), int'(match), int'(!k[1]));
      check($sformatf("R4 irq dis=%0d en=%0d", k[1], k[0]), int'(irq), int'(!k[1] && k[0]));
    end
    gc_dis = 1'b0;
    irq_en = 1'b1;

    // R7 R8 R9 R10: sweep every command byte after a general call
    for (int c = 0; c < 256; c++) begin
      load_addr(RST_ADDR);
      pulse_clr();
      d = 8'((c * 5 + 3) & 255);
      do_start();
      send_byte(8'h00, ack);
      send_byte(8'(c), ack2);
      if (ack2) send_byte(d, ack);
      do_stop();
      exp_ack = (c == 4) || (c == 6);
      exp_addr = exp_ack ? {RST_ADDR[6:3], d[3:1]} : RST_ADDR;
      check($sformatf("R7 R8 R9 R10 cmd %02h ack", c), int'(ack2), int'(exp_ack));
      if (exp_ack) check($sformatf("R8 R9 data ack cmd %02h", c), int'(ack), 1);
      check($sformatf("R8 R9 R10 addr cmd %02h", c), int'(own_addr), int'(exp_addr));
      check($sformatf("R8 R9 R10 gc cmd %02h", c), int'(gc_flag), int'(c != 6));
      check($sformatf("R9 match cmd %02h", c), int'(match), int'(c != 6));
      check($sformatf("R4 R9 irq cmd %02h", c), int'(irq), int'(c != 6));
    end
    load_addr(RST_ADDR);

    // R1: STOP in the middle of an address byte, then a fresh match
    pulse_clr();
    do_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    do_stop();
    check("R1 stop abort flags", int'(match), 0);
    check("R1 stop abort oe", int'(sda_oe), 0);
    do_start();
    send_byte({RST_ADDR, 1'b0}, ack);
    do_stop();
    check("R1 match after stop abort", int'(ack), 1);

    // R1: repeated START in the middle of a byte restarts the address phase
    pulse_clr();
    do_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    do_start();
    send_byte({RST_ADDR, 1'b1}, ack);
    do_stop();
    check("R1 repeated start ack", int'(ack), 1);
    check("R1 repeated start match", int'(match), 1);

    // R1: repeated START after a general call skips the command phase
    pulse_clr();
    do_start();
    send_byte(8'h00, ack);
    do_start();
    send_byte(8'h06, ack);
    do_stop();
    check("R1 restart drops command", int'(ack), 0);
    check("R1 restart keeps addr", int'(own_addr), int'(RST_ADDR));

    // R11: full reload of the own address, and the status clear
    load_addr(7'h11);
    check("R11 addr load", int'(own_addr), 'h11);
    do_start();
    send_byte(8'h22, ack);
    do_stop();
    check("R11 new address acked", int'(ack), 1);
    do_start();
    send_byte({RST_ADDR, 1'b0}, ack);
    do_stop();
    check("R11 old address ignored", int'(ack), 0);
    pulse_clr();
    check("R11 clear match", int'(match), 0);

    // R2: acknowledge pulse never spills into data bits
    check("R2 oe only in ninth clock", oe_glitch, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule